// File: doc/BRIEF.md
# Access-Directed General-Purpose I/O Register

This block is an eight-bit general-purpose I/O register. No direction register exists: the type of the last host access sets the pin direction. A selected write stores the bus value and turns every available pin into an output. A selected read returns the synchronized pin levels and releases the pins to high impedance. The pins stay as outputs through any number of idle cycles until such a read arrives.

A clock-configuration input decides who owns the top two pins. When it is low, those pins belong to other logic. This register then never enables their drivers, and it reads them back as zero. Pin inputs pass through a two-flop synchronizer before they reach the read path. The host bus is a simple synchronous port: one address select and single-cycle write and read strobes.

Top module: `gpio_access_reg`

## Requirements
- R1: After reset, pinOe is all zeros (input mode) and pinOut, which shows the stored value, is all zeros.
- R2: A cycle with sel=1 and wrStb=1 stores wrData. From the next clock edge, pinOut equals that value and every available bit of pinOe is 1.
- R3: When no selected access occurs, pinOe and pinOut hold their values from one cycle to the next.
- R4: A cycle with sel=1, rdStb=1 and wrStb=0 clears every bit of pinOe on the next clock edge.
- R5: During a read cycle (sel=1, rdStb=1, wrStb=0), rdData shows the pin levels as they were two clock edges earlier (two-flop synchronizer), including in the read that releases the pins.
- R6: While upperPinsEn is 0, pinOe[7:6] and rdData[7:6] are 0 and the low six bits behave as normal. While it is 1, all eight bits take part.
- R7: If wrStb and rdStb are both high in a selected cycle, the write takes effect (data stored, pins driven), the pins are not released, and rdData is 0.
- R8: Strobes with sel=0 do not change pinOut or pinOe, and they return rdData of 0.
- R9: rdData is 0 in every cycle that is not a selected read without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Register select from the address decode |
| wrStb | input | 1 | Single-cycle write strobe |
| rdStb | input | 1 | Single-cycle read strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, synchronized pin levels |
| upperPinsEn | input | 1 | Clock-configuration bit; 1 gives pins 7:6 to this register |
| pinIn | input | 8 | Pin input levels from the pads |
| pinOut | output | 8 | Pin output data (stored value) |
| pinOe | output | 8 | Per-pin output enable |

## Verification
The assertions assume that sel and the strobes are synchronous to clk and stable around the edge. They also assume that pinIn may be asynchronous, so they check it only through the synchronizer. The bench changes every input half a cycle away from the sampling edge. It drives upperPinsEn as a quasi-static level and also toggles it between accesses. It sends single-cycle strobes, and in a few places it raises both strobes together or raises them without sel, to cover the write-wins and ignored-access cases.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef struct packed {
    logic loadReg;
    logic dropDrive;
  } ctlStrobes_t;
endpackage

// File: rtl/gpio_ctl.sv
module gpio_ctl
  import gpio_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sel,
  input  logic        wrStb,
  input  logic        rdStb,
  output ctlStrobes_t strb,
  output logic        outMode
);
  logic wrHit, rdHit;

  assign wrHit = sel & wrStb;
  assign rdHit = sel & rdStb & ~wrHit;

  always_comb begin
    strb.loadReg   = wrHit;
    strb.dropDrive = rdHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      outMode <= 1'b0;
    else if (wrHit) outMode <= 1'b1;
    else if (rdHit) outMode <= 1'b0;
  end

  // R2
  write_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sel && wrStb) |=> outMode);
  // R4
  read_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sel && rdStb && !wrStb) |=> !outMode);
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sel && (wrStb || rdStb)) |=> $stable(outMode));
endmodule

// File: rtl/gpio_dp.sv
module gpio_dp
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SHARED_PINS = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic              outMode,
  input  logic              upperPinsEn,
  input  logic [WIDTH-1:0]  wrData,
  input  logic [WIDTH-1:0]  pinIn,
  output logic [WIDTH-1:0]  pinOut,
  output logic [WIDTH-1:0]  pinOe,
  output logic [WIDTH-1:0]  rdData
);
  localparam logic [WIDTH-1:0] ALL_MASK = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] LOW_MASK = ALL_MASK >> SHARED_PINS;

  logic [WIDTH-1:0] dataReg;
  logic [WIDTH-1:0] syncStage [SYNC_STAGES];
  logic [WIDTH-1:0] pinMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             dataReg <= '0;
    else if (strb.loadReg) dataReg <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncStage[i] <= '0;
    end else begin
      syncStage[0] <= pinIn;
      for (int i = 1; i < SYNC_STAGES; i++) syncStage[i] <= syncStage[i-1];
    end
  end

  assign pinMask = upperPinsEn ? ALL_MASK : LOW_MASK;
  assign pinOut  = dataReg;
  assign pinOe   = outMode ? pinMask : '0;
  assign rdData  = strb.dropDrive ? (syncStage[SYNC_STAGES-1] & pinMask) : '0;

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadReg |=> (pinOut == $past(wrData)));
  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadReg |=> $stable(pinOut));
  // R9
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.dropDrive |-> (rdData == '0));
  // R6
  shared_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    !upperPinsEn |-> ((pinOe & ~LOW_MASK) == '0 && (rdData & ~LOW_MASK) == '0));
endmodule

// File: rtl/gpio_access_reg.sv
module gpio_access_reg
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SHARED_PINS = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sel,
  input  logic             wrStb,
  input  logic             rdStb,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  input  logic             upperPinsEn,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe
);
  ctlStrobes_t strb;
  logic        outMode;

  gpio_ctl u_ctl (
    .clk(clk), .rstN(rstN), .sel(sel), .wrStb(wrStb), .rdStb(rdStb),
    .strb(strb), .outMode(outMode)
  );

  gpio_dp #(.WIDTH(WIDTH), .SHARED_PINS(SHARED_PINS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .outMode(outMode),
    .upperPinsEn(upperPinsEn), .wrData(wrData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .rdData(rdData)
  );

  // R7
  both_strobes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sel && wrStb && rdStb) |-> (rdData == '0));
endmodule

// File: tb/gpio_access_reg_test.sv
module gpio_access_reg_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sel = 1'b0, wrStb = 1'b0, rdStb = 1'b0, upperPinsEn = 1'b1;
  logic [7:0] wrData = '0, pinIn = '0;
  logic [7:0] rdData, pinOut, pinOe;

  int compared = 0, mismatched = 0;
  bit modelOut = 0;
  logic [7:0] modelData = '0;
  logic [7:0] pinHist[$];

  always #5 clk = ~clk;

  gpio_access_reg uut (
    .clk(clk), .rstN(rstN), .sel(sel), .wrStb(wrStb), .rdStb(rdStb),
    .wrData(wrData), .rdData(rdData), .upperPinsEn(upperPinsEn),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive inputs for one cycle, compare before the edge, then advance the model
  task automatic step(string req, logic s, logic w, logic r, logic [7:0] d, logic [7:0] p, logic u);
    logic [7:0] mask, expRd;
    sel = s; wrStb = w; rdStb = r; wrData = d; pinIn = p; upperPinsEn = u;
    #1;
    mask  = u ? 8'hFF : 8'h3F;
    expRd = (s && r && !w) ? (pinHist[0] & mask) : 8'h00;
    check(req, "rdData", rdData, expRd);
    check(req, "pinOe", pinOe, modelOut ? mask : 8'h00);
    check(req, "pinOut", pinOut, modelData);
    @(posedge clk);
    if (s && w) begin modelData = d; modelOut = 1; end
    else if (s && r) modelOut = 0;
    pinHist.push_back(p);
    void'(pinHist.pop_front());
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    pinHist.push_back(8'h00); pinHist.push_back(8'h00);
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1", "pinOe", pinOe, 8'h00);
    check("R1", "pinOut", pinOut, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    // R5 input-mode reads see pins two edges late
    step("R5", 0, 0, 0, 8'h00, 8'h3C, 1);
    step("R5", 0, 0, 0, 8'h00, 8'hC3, 1);
    step("R5", 1, 0, 1, 8'h00, 8'h81, 1);
    step("R5", 1, 0, 1, 8'h00, 8'h7E, 1);
    step("R9", 0, 0, 0, 8'h00, 8'h55, 1);
    // R2 write drives pins
    step("R2", 1, 1, 0, 8'hA5, 8'h55, 1);
    // R3 hold while idle
    for (int i = 0; i < 4; i++) step("R3", 0, 0, 0, 8'h11, 8'hAA, 1);
    // R8 strobes without select ignored
    step("R8", 0, 1, 0, 8'h0F, 8'hAA, 1);
    step("R8", 0, 0, 1, 8'h0F, 8'hAA, 1);
    // R4 read releases, same-cycle data (R5)
    step("R4", 1, 0, 1, 8'h00, 8'h99, 1);
    step("R4", 0, 0, 0, 8'h00, 8'h99, 1);
    // R7 both strobes: write wins
    step("R7", 1, 1, 1, 8'h3C, 8'h99, 1);
    step("R7", 0, 0, 0, 8'h00, 8'h99, 1);
    // R6 upper pins withheld
    step("R6", 0, 0, 0, 8'h00, 8'hFF, 0);
    step("R6", 1, 1, 0, 8'hFF, 8'hFF, 0);
    step("R6", 0, 0, 0, 8'h00, 8'hFF, 0);
    step("R6", 1, 0, 1, 8'h00, 8'hFF, 0);
    step("R6", 0, 0, 0, 8'h00, 8'hC0, 1);
    step("R6", 1, 1, 0, 8'h5A, 8'hC0, 1);
    step("R6", 0, 0, 0, 8'h00, 8'hC0, 1);
    step("R6", 1, 0, 1, 8'h00, 8'hC0, 1);
    // varied pattern sweep
    for (int i = 0; i < 40; i++)
      step("R3", (i % 3) != 0, (i % 7) == 1, (i % 5) == 2, 8'(i * 37), 8'(i * 91 + 3), (i % 11) < 8);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule